// File: doc/BRIEF.md
# Power domain switch sequencer

This block sequences the power-up and power-down of one gated power domain. Software asks for the domain to be switched on or off through two request pulses. The block then moves the domain control outputs one step at a time: the two staged power-switch enables, clock disable, isolation, the active-low domain reset, a field of SRAM power-down bits and a bus-protection request. Between groups of steps it waits on the acknowledges that come back from the domain. These are two power-status bits, an SRAM power-down acknowledge field and a bus-protection acknowledge field.

Each wait is bounded by one reloadable cycle counter. If an acknowledge does not arrive within the limit, the block parks in an error state and raises a timeout flag. Only a reset clears that state. Two configuration masks choose which SRAM acknowledge bits and which bus-protection lanes take part. A mask of zero removes the matching handshake from both sequences. The block reports busy, a one-cycle done pulse, its state code and the timeout flag. Every control output comes straight from a register, and no two control steps land in the same cycle. All inputs are taken to be synchronous to `clk`.

Top module: `pds_sequencer`

## Requirements
- R1: After reset, `pwr_ctl` reads reset_n=0 (bit 0), isolation=1 (bit 1), switch-1=0 (bit 2), switch-2=0 (bit 3), clock-disable=1 (bit 4) and bits 7:5 = 0, with every SRAM power-down bit set (bits 8 and up); with SRAM_W=4 that is 12'hF12. In the same condition `bus_prot_req` equals `cfg_bus_mask`, `state_o` is 0 (off), `state_o` is 1 when on and 2 in error, and `busy`, `done` and `timeout` are 0.
- R2: A power-up changes one control item per clock, in this order: switch-1 on, switch-2 on, wait for power, clock-disable off, isolation off, reset_n on, SRAM field cleared, wait for SRAM, bus protection released, wait for the bus. It ends with `pwr_ctl`=12'h00D and `bus_prot_req`=0.
- R3: A power-down changes one control item per clock, in this order: bus protection set, wait for the bus, SRAM field set, wait for SRAM, isolation on, reset_n off, clock-disable on, switch-1 off, switch-2 off, wait for power to fall. It ends with 12'hF12.
- R4: The power-up wait ends only when both status inputs are 1. The power-down wait ends only when both are 0. Any mix keeps the block waiting with its outputs held.
- R5: The SRAM wait on power-up ends when every acknowledge bit selected by `cfg_sram_ack_mask` is 0. The SRAM wait on power-down ends when every selected bit is 1.
- R6: With `cfg_sram_ack_mask`=0, both SRAM waits are skipped and the SRAM field is still written.
- R7: Waiting on bus protection ends when every lane in `cfg_bus_mask` reads 1 after protection is set, or 0 after it is released. With `cfg_bus_mask`=0, both bus steps and their waits are skipped and `bus_prot_req` stays 0.
- R8: If a wait condition is still false after TIMEOUT clocks in that wait, the block enters the error state. There `timeout`=1, `busy`=0, the outputs are frozen and requests are ignored until reset. For a power-up with status input B stuck at 0, `timeout` rises TIMEOUT+3 clocks after the request is sampled.
- R9: A request that arrives while a sequence runs is ignored.
- R10: A request for the present state leaves all outputs unchanged. `done` is 1 in the cycle after the request is sampled and 0 in the cycle after that.
- R11: If `req_on` and `req_off` are sampled in the same cycle, the request that changes the state wins: off goes to power-up, and on goes to power-down.
- R12: `busy` is 1 for the whole of a sequence. When a sequence completes, `done` pulses for exactly one cycle as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Request power-up (sampled each clock) |
| req_off | input | 1 | Request power-down (sampled each clock) |
| cfg_sram_ack_mask | input | SRAM_W | SRAM acknowledge bits taken into account |
| cfg_bus_mask | input | BUS_W | Bus-protection lanes in use |
| pwr_stat_a | input | 1 | Power status from switch stage 1 |
| pwr_stat_b | input | 1 | Power status from switch stage 2 |
| sram_ack | input | SRAM_W | SRAM power-down acknowledges |
| bus_ack | input | BUS_W | Bus-protection acknowledges |
| pwr_ctl | output | SRAM_W+8 | Domain control word (layout in R1) |
| bus_prot_req | output | BUS_W | Bus-protection request, masked |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| state_o | output | 5 | State code |
| timeout | output | 1 | A wait expired; block halted |

## Verification
The two functions that can fall in the same cycle are the power-up and the power-down request decoders. `req_on` and `req_off` are both sampled on one edge. The bench raises both lines together for one clock, first with the domain off and then with it on. It judges the result by the state reached at the end of the sequence and by its done pulse. The expected winner in each case is the request that moves the domain away from its present state.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [4:0] {
    ST_OFF = 5'd0, ST_ON = 5'd1, ST_ERR = 5'd2,
    U_SW1, U_SW2, U_PWAIT, U_CLK, U_ISO, U_RST, U_SRAM, U_SWAIT, U_BUS, U_BWAIT,
    D_BUS, D_BWAIT, D_SRAM, D_SWAIT, D_ISO, D_RST, D_CLK, D_SW1, D_SW2, D_PWAIT
  } pds_state_e;

  localparam int CTL_RSTN     = 0;
  localparam int CTL_ISO      = 1;
  localparam int CTL_SW1      = 2;
  localparam int CTL_SW2      = 3;
  localparam int CTL_CKD      = 4;
  localparam int CTL_SRAM_LSB = 8;

  function automatic logic is_wait(pds_state_e s);
    return s inside {U_PWAIT, U_SWAIT, U_BWAIT, D_BWAIT, D_SWAIT, D_PWAIT};
  endfunction
endpackage

// File: rtl/pds_ack_eval.sv
module pds_ack_eval #(
  parameter int SRAM_W = 4,
  parameter int BUS_W  = 4
) (
  input  logic              stat_a,
  input  logic              stat_b,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic [SRAM_W-1:0] sram_mask,
  input  logic [BUS_W-1:0]  bus_ack,
  input  logic [BUS_W-1:0]  bus_mask,
  output logic              pwr_is_on,
  output logic              pwr_is_off,
  output logic              sram_all_clr,
  output logic              sram_all_set,
  output logic              bus_all_set,
  output logic              bus_all_clr,
  output logic              sram_skip,
  output logic              bus_skip
);
  logic [SRAM_W-1:0] s_hit, s_miss;
  logic [BUS_W-1:0]  b_hit, b_miss;

  for (genvar i = 0; i < SRAM_W; i++) begin : g_sram
    assign s_hit[i]  = sram_mask[i] &  sram_ack[i];
    assign s_miss[i] = sram_mask[i] & ~sram_ack[i];
  end

  for (genvar j = 0; j < BUS_W; j++) begin : g_bus
    assign b_hit[j]  = bus_mask[j] &  bus_ack[j];
    assign b_miss[j] = bus_mask[j] & ~bus_ack[j];
  end

  assign pwr_is_on    =  stat_a &  stat_b;
  assign pwr_is_off   = ~stat_a & ~stat_b;
  assign sram_all_clr = ~|s_hit;
  assign sram_all_set = ~|s_miss;
  assign bus_all_set  = ~|b_miss;
  assign bus_all_clr  = ~|b_hit;
  assign sram_skip    = ~|sram_mask;
  assign bus_skip     = ~|bus_mask;
endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= RELOAD;
    else if (load)               cnt <= RELOAD;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int SRAM_W = 4,
  parameter int BUS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              pwr_is_on,
  input  logic              pwr_is_off,
  input  logic              sram_all_clr,
  input  logic              sram_all_set,
  input  logic              bus_all_set,
  input  logic              bus_all_clr,
  input  logic              sram_skip,
  input  logic              bus_skip,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              rstn_q,
  output logic              iso_q,
  output logic              sw1_q,
  output logic              sw2_q,
  output logic              ckd_q,
  output logic [SRAM_W-1:0] pdn_q,
  output logic [BUS_W-1:0]  bus_q,
  output logic              done_q,
  output logic              timeout_q,
  output logic              busy,
  output pds_state_e        state_q
);
  pds_state_e nxt;
  logic       done_n;
  logic       ok;

  always_comb begin
    nxt    = state_q;
    done_n = 1'b0;
    ok     = 1'b0;
    unique case (state_q)
      ST_OFF:  if (req_on) nxt = U_SW1; else if (req_off) done_n = 1'b1;
      ST_ON:   if (req_off) nxt = bus_skip ? D_SRAM : D_BUS;
               else if (req_on) done_n = 1'b1;
      ST_ERR:  nxt = ST_ERR;
      U_SW1:   nxt = U_SW2;
      U_SW2:   nxt = U_PWAIT;
      U_PWAIT: begin ok = pwr_is_on; if (ok) nxt = U_CLK; end
      U_CLK:   nxt = U_ISO;
      U_ISO:   nxt = U_RST;
      U_RST:   nxt = U_SRAM;
      U_SRAM:  nxt = !sram_skip ? U_SWAIT : (bus_skip ? ST_ON : U_BUS);
      U_SWAIT: begin ok = sram_all_clr; if (ok) nxt = bus_skip ? ST_ON : U_BUS; end
      U_BUS:   nxt = U_BWAIT;
      U_BWAIT: begin ok = bus_all_clr; if (ok) nxt = ST_ON; end
      D_BUS:   nxt = D_BWAIT;
      D_BWAIT: begin ok = bus_all_set; if (ok) nxt = D_SRAM; end
      D_SRAM:  nxt = sram_skip ? D_ISO : D_SWAIT;
      D_SWAIT: begin ok = sram_all_set; if (ok) nxt = D_ISO; end
      D_ISO:   nxt = D_RST;
      D_RST:   nxt = D_CLK;
      D_CLK:   nxt = D_SW1;
      D_SW1:   nxt = D_SW2;
      D_SW2:   nxt = D_PWAIT;
      D_PWAIT: begin ok = pwr_is_off; if (ok) nxt = ST_OFF; end
      default: nxt = ST_ERR;
    endcase
    if (is_wait(state_q) && !ok && tmr_expired) nxt = ST_ERR;
    if (busy && (nxt == ST_ON || nxt == ST_OFF)) done_n = 1'b1;
  end

  assign busy     = !(state_q inside {ST_OFF, ST_ON, ST_ERR});
  assign tmr_run  = is_wait(state_q);
  assign tmr_load = is_wait(nxt) && (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      rstn_q    <= 1'b0;
      iso_q     <= 1'b1;
      sw1_q     <= 1'b0;
      sw2_q     <= 1'b0;
      ckd_q     <= 1'b1;
      pdn_q     <= '1;
      bus_q     <= '1;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= nxt;
      done_q  <= done_n;
      if (nxt == ST_ERR) timeout_q <= 1'b1;
      case (state_q)
        U_SW1:  sw1_q  <= 1'b1;
        U_SW2:  sw2_q  <= 1'b1;
        U_CLK:  ckd_q  <= 1'b0;
        U_ISO:  iso_q  <= 1'b0;
        U_RST:  rstn_q <= 1'b1;
        U_SRAM: pdn_q  <= '0;
        U_BUS:  bus_q  <= '0;
        D_BUS:  bus_q  <= '1;
        D_SRAM: pdn_q  <= '1;
        D_ISO:  iso_q  <= 1'b1;
        D_RST:  rstn_q <= 1'b0;
        D_CLK:  ckd_q  <= 1'b1;
        D_SW1:  sw1_q  <= 1'b0;
        D_SW2:  sw2_q  <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer
  import pds_pkg::*;
#(
  parameter int SRAM_W  = 4,
  parameter int BUS_W   = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic [SRAM_W-1:0] cfg_sram_ack_mask,
  input  logic [BUS_W-1:0]  cfg_bus_mask,
  input  logic              pwr_stat_a,
  input  logic              pwr_stat_b,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic [BUS_W-1:0]  bus_ack,
  output logic [SRAM_W+7:0] pwr_ctl,
  output logic [BUS_W-1:0]  bus_prot_req,
  output logic              done,
  output logic              busy,
  output logic [4:0]        state_o,
  output logic              timeout
);
  logic pwr_is_on, pwr_is_off, sram_all_clr, sram_all_set;
  logic bus_all_set, bus_all_clr, sram_skip, bus_skip;
  logic tmr_load, tmr_run, tmr_expired;
  logic rstn_q, iso_q, sw1_q, sw2_q, ckd_q;
  logic [SRAM_W-1:0] pdn_q;
  logic [BUS_W-1:0]  bus_q;
  pds_state_e        st;

  pds_ack_eval #(.SRAM_W(SRAM_W), .BUS_W(BUS_W)) u_eval (
    .stat_a(pwr_stat_a), .stat_b(pwr_stat_b),
    .sram_ack(sram_ack), .sram_mask(cfg_sram_ack_mask),
    .bus_ack(bus_ack), .bus_mask(cfg_bus_mask),
    .pwr_is_on(pwr_is_on), .pwr_is_off(pwr_is_off),
    .sram_all_clr(sram_all_clr), .sram_all_set(sram_all_set),
    .bus_all_set(bus_all_set), .bus_all_clr(bus_all_clr),
    .sram_skip(sram_skip), .bus_skip(bus_skip)
  );

  pds_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
    .expired(tmr_expired)
  );

  pds_fsm #(.SRAM_W(SRAM_W), .BUS_W(BUS_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .pwr_is_on(pwr_is_on), .pwr_is_off(pwr_is_off),
    .sram_all_clr(sram_all_clr), .sram_all_set(sram_all_set),
    .bus_all_set(bus_all_set), .bus_all_clr(bus_all_clr),
    .sram_skip(sram_skip), .bus_skip(bus_skip),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_run(tmr_run),
    .rstn_q(rstn_q), .iso_q(iso_q), .sw1_q(sw1_q), .sw2_q(sw2_q),
    .ckd_q(ckd_q), .pdn_q(pdn_q), .bus_q(bus_q),
    .done_q(done), .timeout_q(timeout), .busy(busy), .state_q(st)
  );

  always_comb begin
    pwr_ctl                          = '0;
    pwr_ctl[CTL_RSTN]                = rstn_q;
    pwr_ctl[CTL_ISO]                 = iso_q;
    pwr_ctl[CTL_SW1]                 = sw1_q;
    pwr_ctl[CTL_SW2]                 = sw2_q;
    pwr_ctl[CTL_CKD]                 = ckd_q;
    pwr_ctl[CTL_SRAM_LSB +: SRAM_W]  = pdn_q;
  end

  assign bus_prot_req = bus_q & cfg_bus_mask;
  assign state_o      = st;
endmodule

// File: rtl/pds_sequencer_chk.sv
module pds_sequencer_chk #(
  parameter int SRAM_W = 4,
  parameter int BUS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRAM_W+7:0] pwr_ctl,
  input logic [BUS_W-1:0]  bus_prot_req,
  input logic [BUS_W-1:0]  cfg_bus_mask,
  input logic              done,
  input logic              busy,
  input logic [4:0]        state_o,
  input logic              timeout
);
  logic [SRAM_W-1:0] pdn;
  assign pdn = pwr_ctl[SRAM_W+7:8];

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pwr_ctl[4:0] ^ $past(pwr_ctl[4:0]))
              + int'(pdn != $past(pdn))
              + int'(bus_prot_req != $past(bus_prot_req))) <= 1);

  p_reset_after_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ctl[0] |-> (!pwr_ctl[4] && pwr_ctl[2] && pwr_ctl[3]));

  p_iso_off_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ctl[1] |-> (pwr_ctl[2] && pwr_ctl[3]));

  p_sram_awake_in_reset_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn != '1) |-> pwr_ctl[0]);

  p_bus_open_sram_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_prot_req & cfg_bus_mask) != cfg_bus_mask) |-> (pdn == '0));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (state_o == 5'd2 && !busy));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> ($stable(pwr_ctl) && timeout));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout));
endmodule

bind pds_sequencer pds_sequencer_chk #(.SRAM_W(SRAM_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ctl(pwr_ctl), .bus_prot_req(bus_prot_req),
  .cfg_bus_mask(cfg_bus_mask), .done(done), .busy(busy), .state_o(state_o),
  .timeout(timeout)
);

// File: tb/pds_sequencer_test.sv
`timescale 1ns/1ps
module pds_sequencer_test;
  localparam int SW = 4;
  localparam int BW = 4;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0;
  logic [SW-1:0] cfg_sram_ack_mask = '1;
  logic [BW-1:0] cfg_bus_mask = '1;
  logic pwr_stat_a, pwr_stat_b;
  logic [SW-1:0] sram_ack;
  logic [BW-1:0] bus_ack;
  logic [SW+7:0] pwr_ctl;
  logic [BW-1:0] bus_prot_req;
  logic done, busy, timeout;
  logic [4:0] state_o;

  int total = 0, bad = 0;

  // environment fault modes: 0 follow, 2 stuck at 0, 3 stuck at 1
  logic [1:0] a_mode = 0, b_mode = 0, s_mode = 0, k_mode = 0;
  logic [1:0] a_d;
  logic [2:0] b_d;
  logic [SW-1:0] s_d1, s_d2;
  logic [BW-1:0] k_d;

  always #4 clk = ~clk;

  pds_sequencer #(.SRAM_W(SW), .BUS_W(BW), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .cfg_sram_ack_mask(cfg_sram_ack_mask), .cfg_bus_mask(cfg_bus_mask),
    .pwr_stat_a(pwr_stat_a), .pwr_stat_b(pwr_stat_b),
    .sram_ack(sram_ack), .bus_ack(bus_ack), .pwr_ctl(pwr_ctl),
    .bus_prot_req(bus_prot_req), .done(done), .busy(busy),
    .state_o(state_o), .timeout(timeout)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d <= '0; b_d <= '0; s_d1 <= '1; s_d2 <= '1; k_d <= '1;
    end else begin
      a_d  <= {a_d[0], pwr_ctl[2]};
      b_d  <= {b_d[1:0], pwr_ctl[3]};
      s_d1 <= pwr_ctl[SW+7:8];
      s_d2 <= s_d1;
      k_d  <= bus_prot_req;
    end
  end

  assign pwr_stat_a = (a_mode == 0) ? a_d[1] : a_mode[0];
  assign pwr_stat_b = (b_mode == 0) ? b_d[2] : b_mode[0];
  assign sram_ack   = (s_mode == 0) ? s_d2 : {SW{s_mode[0]}};
  assign bus_ack    = (k_mode == 0) ? k_d  : {BW{k_mode[0]}};

  // step monitor: codes 0..4 control bits, 8 SRAM field, 9 bus request
  logic [31:0] seq;
  int multi = 0;
  logic [SW+7:0] p_ctl;
  logic [BW-1:0] p_bus;
  always @(negedge clk) begin
    int n;
    n = 0;
    if (rst_n) begin
      for (int i = 0; i < 5; i++)
        if (pwr_ctl[i] != p_ctl[i]) begin seq = (seq << 4) | i; n++; end
      if (pwr_ctl[SW+7:8] != p_ctl[SW+7:8]) begin seq = (seq << 4) | 8; n++; end
      if (bus_prot_req != p_bus) begin seq = (seq << 4) | 9; n++; end
      if (n > 1) multi++;
    end
    p_ctl = pwr_ctl;
    p_bus = bus_prot_req;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [SW-1:0] sm, logic [BW-1:0] bm);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_sram_ack_mask = sm; cfg_bus_mask = bm;
    a_mode = 0; b_mode = 0; s_mode = 0; k_mode = 0;
    req_on = 0; req_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(logic on, logic off);
    @(negedge clk);
    req_on = on; req_off = off;
    @(negedge clk);
    req_on = 0; req_off = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 300; i++) begin
      if (done || timeout) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset('1, '1);
    chk("R1 ctl", pwr_ctl, 12'hF12);
    chk("R1 bus", bus_prot_req, 4'hF);
    chk("R1 flags", {state_o, busy, done, timeout}, 0);
  endtask

  task automatic t_up();
    int bz;
    seq = 0; bz = 0;
    pulse(1, 0);
    for (int i = 0; i < 300 && !done; i++) begin
      if (busy) bz++;
      @(negedge clk);
    end
    chk("R12 done", done, 1);
    chk("R12 busy", busy, 0);
    chk("R12 busy-span", bz > 8, 1);
    chk("R2 order", seq, 32'h2341089);
    chk("R2 ctl", pwr_ctl, 12'h00D);
    chk("R2 bus", bus_prot_req, 0);
    chk("R2 state", state_o, 1);
    @(negedge clk);
    chk("R12 done-once", done, 0);
  endtask

  task automatic t_redundant(logic on, logic [11:0] ctl);
    pulse(on, !on);
    chk("R10 done", done, 1);
    chk("R10 ctl", pwr_ctl, ctl);
    chk("R10 busy", busy, 0);
    @(negedge clk);
    chk("R10 done-drop", done, 0);
  endtask

  task automatic t_down_ignore();
    seq = 0;
    pulse(0, 1);
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 1);
    pulse(1, 0);
    wait_end();
    chk("R3 done", done, 1);
    chk("R3 order", seq, 32'h9810423);
    chk("R3 ctl", pwr_ctl, 12'hF12);
    repeat (4) @(negedge clk);
    chk("R9 stays off", {state_o, busy}, 0);
  endtask

  task automatic t_both();
    pulse(1, 1);
    chk("R11 off->up", busy, 1);
    wait_end();
    chk("R11 on", state_o, 1);
    pulse(1, 1);
    chk("R11 on->down", busy, 1);
    wait_end();
    chk("R11 off", {state_o, pwr_ctl}, {5'd0, 12'hF12});
  endtask

  task automatic t_mix();
    b_mode = 2;
    pulse(1, 0);
    repeat (9) @(negedge clk);
    chk("R4 up waiting", {busy, pwr_ctl[4:2]}, 4'b1111);
    b_mode = 0;
    wait_end();
    chk("R4 up done", {state_o, timeout}, {5'd1, 1'b0});
    a_mode = 3;
    pulse(0, 1);
    repeat (16) @(negedge clk);
    chk("R4 down waiting", {busy, state_o == 5'd1, pwr_ctl[2]}, 3'b100);
    a_mode = 0;
    wait_end();
    chk("R4 down done", {state_o, timeout}, 0);
  endtask

  task automatic t_pwr_timeout();
    int n;
    b_mode = 2;
    pulse(1, 0);
    n = 1;
    while (!timeout && n < 100) begin @(negedge clk); n++; end
    chk("R8 latency", n, TO + 3);
    chk("R8 halt", {state_o, busy}, {5'd2, 1'b0});
    chk("R8 frozen", pwr_ctl, 12'hF1E);
    pulse(0, 1);
    repeat (2) @(negedge clk);
    chk("R8 ignore", {state_o, pwr_ctl}, {5'd2, 12'hF1E});
    do_reset('1, '1);
  endtask

  task automatic t_sram_pol();
    s_mode = 3;
    pulse(1, 0);
    wait_end();
    chk("R5 up stuck1", {timeout, pwr_ctl, bus_prot_req}, {1'b1, 12'h00D, 4'hF});
    do_reset('1, '1);
    pulse(1, 0);
    wait_end();
    s_mode = 2;
    pulse(0, 1);
    wait_end();
    chk("R5 down stuck0", {timeout, pwr_ctl}, {1'b1, 12'hF0D});
    do_reset('1, '1);
  endtask

  task automatic t_sram_skip();
    do_reset('0, '1);
    s_mode = 3;
    pulse(1, 0);
    wait_end();
    chk("R6 up skip", {timeout, state_o, pwr_ctl}, {1'b0, 5'd1, 12'h00D});
    s_mode = 2;
    pulse(0, 1);
    wait_end();
    chk("R6 down skip", {timeout, state_o, pwr_ctl}, {1'b0, 5'd0, 12'hF12});
  endtask

  task automatic t_bus();
    do_reset('1, '0);
    k_mode = 2;
    seq = 0;
    pulse(1, 0);
    wait_end();
    chk("R7 up skip", {timeout, state_o, seq}, {1'b0, 5'd1, 32'h234108});
    seq = 0;
    pulse(0, 1);
    wait_end();
    chk("R7 down skip", {timeout, state_o, seq}, {1'b0, 5'd0, 32'h810423});
    chk("R7 req low", bus_prot_req, 0);
    do_reset('1, '1);
    pulse(1, 0);
    wait_end();
    k_mode = 2;
    pulse(0, 1);
    wait_end();
    chk("R7 set wait", {timeout, pwr_ctl, bus_prot_req}, {1'b1, 12'h00D, 4'hF});
    do_reset('1, '1);
  endtask

  initial begin
    t_reset();
    t_up();
    t_redundant(1, 12'h00D);
    t_down_ignore();
    t_redundant(0, 12'hF12);
    t_both();
    t_mix();
    t_pwr_timeout();
    t_sram_pol();
    t_sram_skip();
    t_bus();
    chk("R2 single step", multi, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule